// File: doc/BRIEF.md
# Stream Address Generator with Descriptors

This block turns stream load and store commands into a series of memory request addresses. Software first programs a small bank of stream descriptors. Each descriptor holds a first address, a limit address, a stride, a walking direction, a mode bit and a store flag. A start command then names one descriptor, and the block runs that stream to completion.

The mode bit selects one of two sources. In strided mode the block produces the addresses itself by stepping from the first address toward the limit. In gather/scatter mode it passes through addresses that arrive on a valid/ready index port, until a beat marked last has been taken.

Every request is steered to exactly one of three valid/ready request ports: the stream cache, local memory or the network. A cache hit reported by the tag check takes priority. Otherwise the request goes to local memory if the address's node field names this node, and to the network if it does not. Back-pressure on the active port stalls the generator, and no address is lost or repeated. A done pulse marks the end of each stream.

Top module: `sag_top`

## Requirements
- R1: After reset, `busy`, `done`, `idx_ready` and all three request valids are low.
- R2: A cycle with `cfg_we` high stores all descriptor fields into entry `cfg_sel`. A `go` pulse while idle launches entry `go_sel` using the values held at that moment. A `go` pulse while `busy` is high is ignored and is not queued. Rewriting a descriptor while a stream is active leaves the active stream unchanged, and the new values take effect on the next launch.
- R3: In strided mode with `cfg_descend`=0, the requests carry the first address, then the first address plus the stride, and so on, for as long as the address is unsigned ≤ the limit. A step that carries beyond the top of the address space ends the stream.
- R4: In strided mode with `cfg_descend`=1, each step subtracts the stride. Requests continue while the address is ≥ the limit, and a step that borrows below zero ends the stream.
- R5: A strided stream whose first address already lies past the limit issues no request and still pulses `done`. A stride of zero issues exactly one request, at the first address, when that address is within the limit.
- R6: In gather/scatter mode, each index beat taken (`idx_valid` and `idx_ready` both high at a clock edge) becomes exactly one request carrying `idx_addr`, in arrival order. The beat with `idx_last` high is the final one. `idx_ready` stays low while the block is idle.
- R7: Steering is decided when the address is taken into the output slot. If `lkup_hit` (the tag-check answer for `lkup_addr`) is high, the request goes to the cache port. Otherwise, if address bits [NODE_LSB+NODE_W-1:NODE_LSB] equal `node_id`, it goes to the local port. Otherwise it goes to the network port. At most one valid is high at a time.
- R8: A raised valid stays high, with its address and store flag unchanged, until its ready is seen. With every ready held high, one request leaves per cycle.
- R9: `done` is a single-cycle pulse that comes after the last request of a stream has been accepted. `busy` is high from the cycle after the launch until `done`, and is low in the cycle in which `done` is high.
- R10: Each request carries the store flag of the descriptor that launched it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | NODE_W | Identity of this node |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_sel | input | SEL_W | Descriptor index to write |
| cfg_start | input | ADDR_W | First address |
| cfg_end | input | ADDR_W | Limit address (inclusive) |
| cfg_stride | input | STRIDE_W | Unsigned step size |
| cfg_descend | input | 1 | 1 = walk downward |
| cfg_gather | input | 1 | 1 = take addresses from index port |
| cfg_store | input | 1 | 1 = requests are stores |
| go | input | 1 | Launch pulse |
| go_sel | input | SEL_W | Descriptor index to launch |
| busy | output | 1 | Stream active |
| done | output | 1 | End-of-stream pulse |
| idx_valid | input | 1 | Index beat valid |
| idx_ready | output | 1 | Index beat accepted |
| idx_addr | input | ADDR_W | Gather/scatter address |
| idx_last | input | 1 | Final index beat |
| lkup_addr | output | ADDR_W | Candidate address for tag check |
| lkup_hit | input | 1 | Tag check hit for lkup_addr (same cycle) |
| cq_valid | output | 1 | Cache request valid |
| cq_ready | input | 1 | Cache request ready |
| cq_addr | output | ADDR_W | Cache request address |
| cq_store | output | 1 | Cache request is a store |
| lm_valid | output | 1 | Local memory request valid |
| lm_ready | input | 1 | Local memory request ready |
| lm_addr | output | ADDR_W | Local memory request address |
| lm_store | output | 1 | Local memory request is a store |
| nw_valid | output | 1 | Network request valid |
| nw_ready | input | 1 | Network request ready |
| nw_addr | output | ADDR_W | Network request address |
| nw_store | output | 1 | Network request is a store |

## Verification
The generator is run on several kinds of stream:
- An ascending stream that lands exactly on its limit checks the inclusive bound.
- A descending stream whose limit falls between two steps checks that the walk stops short of the limit.
- Empty, zero-stride and wrapping streams check the termination rules at their edges.
- A gather stream with gaps between beats checks that the index port drives the stream beat by beat rather than by a cycle count.

Routing is checked by repeating the same addresses with the tag-check hit enabled and then disabled, and by a stream that crosses a node boundary; together these show that a cache hit outranks a node match. A toggling ready pattern checks that stalled requests are held without loss. A start command issued, and a descriptor rewritten, while a stream is already running check that the active stream is isolated from both.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum logic [1:0] {
    RT_CACHE = 2'd0,
    RT_LOCAL = 2'd1,
    RT_NET   = 2'd2
  } route_e;

  localparam int NUM_PORTS = 3;
endpackage

// File: rtl/sag_desc_file.sv
module sag_desc_file #(
  parameter int NUM_DESC = 4,
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16,
  localparam int SEL_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [ADDR_W-1:0]   wr_start,
  input  logic [ADDR_W-1:0]   wr_end,
  input  logic [STRIDE_W-1:0] wr_stride,
  input  logic                wr_descend,
  input  logic                wr_gather,
  input  logic                wr_store,
  input  logic [SEL_W-1:0]    rd_sel,
  output logic [ADDR_W-1:0]   rd_start,
  output logic [ADDR_W-1:0]   rd_end,
  output logic [STRIDE_W-1:0] rd_stride,
  output logic                rd_descend,
  output logic                rd_gather,
  output logic                rd_store
);
  typedef struct packed {
    logic [ADDR_W-1:0]   first;
    logic [ADDR_W-1:0]   limit;
    logic [STRIDE_W-1:0] step;
    logic                down;
    logic                gath;
    logic                st;
  } entry_t;

  entry_t ent [NUM_DESC];
  entry_t rd_ent;

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_entry
    entry_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(g))) begin
        q.first <= wr_start;
        q.limit <= wr_end;
        q.step  <= wr_stride;
        q.down  <= wr_descend;
        q.gath  <= wr_gather;
        q.st    <= wr_store;
      end
    end
    assign ent[g] = q;
  end

  always_comb begin
    rd_ent = '0;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (rd_sel == SEL_W'(i)) rd_ent = ent[i];
    end
  end

  assign rd_start   = rd_ent.first;
  assign rd_end     = rd_ent.limit;
  assign rd_stride  = rd_ent.step;
  assign rd_descend = rd_ent.down;
  assign rd_gather  = rd_ent.gath;
  assign rd_store   = rd_ent.st;
endmodule

// File: rtl/sag_stride_step.sv
module sag_stride_step #(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16
) (
  input  logic [ADDR_W-1:0]   cur,
  input  logic [ADDR_W-1:0]   limit,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                descend,
  output logic                in_range,
  output logic [ADDR_W-1:0]   next,
  output logic                wrap,
  output logic                zero_step
);
  logic [ADDR_W:0] ext_cur;
  logic [ADDR_W:0] ext_step;
  logic [ADDR_W:0] sum;

  assign ext_cur  = {1'b0, cur};
  assign ext_step = (ADDR_W + 1)'(stride);

  always_comb begin
    if (descend) begin
      sum      = ext_cur - ext_step;
      in_range = (cur >= limit);
    end else begin
      sum      = ext_cur + ext_step;
      in_range = (cur <= limit);
    end
  end

  assign next      = sum[ADDR_W-1:0];
  assign wrap      = sum[ADDR_W];
  assign zero_step = (stride == '0);
endmodule

// File: rtl/sag_router.sv
module sag_router
  import sag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NODE_W   = 4,
  parameter int NODE_LSB = 24
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              hit,
  input  logic [NODE_W-1:0] node_id,
  output route_e            route
);
  logic [NODE_W-1:0] node_field;
  assign node_field = addr[NODE_LSB +: NODE_W];

  always_comb begin
    if (hit)                        route = RT_CACHE;
    else if (node_field == node_id) route = RT_LOCAL;
    else                            route = RT_NET;
  end
endmodule

// File: rtl/sag_out_slot.sv
module sag_out_slot
  import sag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [ADDR_W-1:0]    ld_addr,
  input  route_e               ld_route,
  input  logic                 ld_store,
  input  logic [NUM_PORTS-1:0] port_ready,
  output logic [NUM_PORTS-1:0] port_valid,
  output logic [ADDR_W-1:0]    addr,
  output logic                 store,
  output logic                 full,
  output logic                 free
);
  logic   v_q;
  route_e route_q;
  logic   fire;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_valid[p] = v_q && (route_q == route_e'(p));
  end

  assign fire = |(port_valid & port_ready);
  assign free = !v_q || fire;
  assign full = v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      route_q <= RT_CACHE;
      addr    <= '0;
      store   <= 1'b0;
    end else if (load) begin
      v_q     <= 1'b1;
      route_q <= ld_route;
      addr    <= ld_addr;
      store   <= ld_store;
    end else if (fire) begin
      v_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sag_top.sv
module sag_top
  import sag_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16,
  parameter int NODE_W   = 4,
  parameter int NODE_LSB = 24,
  localparam int SEL_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NODE_W-1:0]   node_id,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [ADDR_W-1:0]   cfg_start,
  input  logic [ADDR_W-1:0]   cfg_end,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic                cfg_descend,
  input  logic                cfg_gather,
  input  logic                cfg_store,
  input  logic                go,
  input  logic [SEL_W-1:0]    go_sel,
  output logic                busy,
  output logic                done,
  input  logic                idx_valid,
  output logic                idx_ready,
  input  logic [ADDR_W-1:0]   idx_addr,
  input  logic                idx_last,
  output logic [ADDR_W-1:0]   lkup_addr,
  input  logic                lkup_hit,
  output logic                cq_valid,
  input  logic                cq_ready,
  output logic [ADDR_W-1:0]   cq_addr,
  output logic                cq_store,
  output logic                lm_valid,
  input  logic                lm_ready,
  output logic [ADDR_W-1:0]   lm_addr,
  output logic                lm_store,
  output logic                nw_valid,
  input  logic                nw_ready,
  output logic [ADDR_W-1:0]   nw_addr,
  output logic                nw_store
);
  // descriptor read side
  logic [ADDR_W-1:0]   d_start, d_end;
  logic [STRIDE_W-1:0] d_stride;
  logic                d_descend, d_gather, d_store;

  sag_desc_file #(
    .NUM_DESC(NUM_DESC), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)
  ) u_desc (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_sel(cfg_sel),
    .wr_start(cfg_start), .wr_end(cfg_end), .wr_stride(cfg_stride),
    .wr_descend(cfg_descend), .wr_gather(cfg_gather), .wr_store(cfg_store),
    .rd_sel(go_sel),
    .rd_start(d_start), .rd_end(d_end), .rd_stride(d_stride),
    .rd_descend(d_descend), .rd_gather(d_gather), .rd_store(d_store)
  );

  // active stream copy, frozen at launch
  logic                run_q, fin_q, done_q;
  logic [ADDR_W-1:0]   cur_q, act_end;
  logic [STRIDE_W-1:0] act_stride;
  logic                act_descend, act_gather, act_store;

  logic [ADDR_W-1:0] step_next;
  logic              step_in_range, step_wrap, step_zero;

  sag_stride_step #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_step (
    .cur(cur_q), .limit(act_end), .stride(act_stride), .descend(act_descend),
    .in_range(step_in_range), .next(step_next), .wrap(step_wrap),
    .zero_step(step_zero)
  );

  logic              exhausted, cand_valid, advance, finish_now, go_take;
  logic [ADDR_W-1:0] cand_addr;
  route_e            cand_route;
  logic              slot_free, slot_full;
  logic [NUM_PORTS-1:0] pv, pr;
  logic [ADDR_W-1:0] slot_addr;
  logic              slot_store;

  assign exhausted  = fin_q || (!act_gather && !step_in_range);
  assign cand_addr  = act_gather ? idx_addr : cur_q;
  assign cand_valid = run_q && !exhausted && (!act_gather || idx_valid);
  assign advance    = cand_valid && slot_free;
  assign finish_now = run_q && exhausted && !slot_full;
  assign go_take    = go && !run_q;

  assign lkup_addr = cand_addr;
  assign idx_ready = run_q && act_gather && !fin_q && slot_free;

  sag_router #(.ADDR_W(ADDR_W), .NODE_W(NODE_W), .NODE_LSB(NODE_LSB)) u_route (
    .addr(cand_addr), .hit(lkup_hit), .node_id(node_id), .route(cand_route)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      fin_q       <= 1'b0;
      done_q      <= 1'b0;
      cur_q       <= '0;
      act_end     <= '0;
      act_stride  <= '0;
      act_descend <= 1'b0;
      act_gather  <= 1'b0;
      act_store   <= 1'b0;
    end else begin
      done_q <= finish_now;
      if (go_take) begin
        run_q       <= 1'b1;
        fin_q       <= 1'b0;
        cur_q       <= d_start;
        act_end     <= d_end;
        act_stride  <= d_stride;
        act_descend <= d_descend;
        act_gather  <= d_gather;
        act_store   <= d_store;
      end else if (run_q) begin
        if (advance && !act_gather) begin
          cur_q <= step_next;
          if (step_wrap || step_zero) fin_q <= 1'b1;
        end
        if (advance && act_gather && idx_last) fin_q <= 1'b1;
        if (finish_now) run_q <= 1'b0;
      end
    end
  end

  assign pr = {nw_ready, lm_ready, cq_ready};

  sag_out_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .load(advance), .ld_addr(cand_addr), .ld_route(cand_route),
    .ld_store(act_store),
    .port_ready(pr), .port_valid(pv),
    .addr(slot_addr), .store(slot_store),
    .full(slot_full), .free(slot_free)
  );

  assign cq_valid = pv[RT_CACHE];
  assign lm_valid = pv[RT_LOCAL];
  assign nw_valid = pv[RT_NET];
  assign cq_addr  = slot_addr;
  assign lm_addr  = slot_addr;
  assign nw_addr  = slot_addr;
  assign cq_store = slot_store;
  assign lm_store = slot_store;
  assign nw_store = slot_store;

  assign busy = run_q;
  assign done = done_q;
endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
  parameter int ADDR_W   = 32,
  parameter int NODE_W   = 4,
  parameter int NODE_LSB = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NODE_W-1:0] node_id,
  input logic              busy,
  input logic              done,
  input logic              idx_ready,
  input logic              cq_valid,
  input logic              cq_ready,
  input logic [ADDR_W-1:0] cq_addr,
  input logic              lm_valid,
  input logic              lm_ready,
  input logic [ADDR_W-1:0] lm_addr,
  input logic              nw_valid,
  input logic              nw_ready,
  input logic [ADDR_W-1:0] nw_addr
);
  logic stalled;
  assign stalled = (cq_valid && !cq_ready) || (lm_valid && !lm_ready) ||
                   (nw_valid && !nw_ready);

  // R7: only one port offered at a time
  p_one_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cq_valid, lm_valid, nw_valid}));

  // R7: local port only for this node's addresses
  p_local_node_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lm_valid |-> (lm_addr[NODE_LSB +: NODE_W] == node_id));

  // R7: network port only for foreign addresses
  p_net_node_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nw_valid |-> (nw_addr[NODE_LSB +: NODE_W] != node_id));

  // R8: a stalled request is held unchanged
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> ($stable({cq_valid, lm_valid, nw_valid}) && $stable(cq_addr)
                 && $stable(lm_addr) && $stable(nw_addr)));

  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: done only once the stream is no longer busy
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: nothing is offered while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(cq_valid || lm_valid || nw_valid));

  // R6: index port closed while idle
  p_idx_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ready |-> busy);
endmodule

bind sag_top sag_checker #(
  .ADDR_W(ADDR_W), .NODE_W(NODE_W), .NODE_LSB(NODE_LSB)
) u_sag_checker (
  .clk(clk), .rst_n(rst_n), .node_id(node_id), .busy(busy), .done(done),
  .idx_ready(idx_ready),
  .cq_valid(cq_valid), .cq_ready(cq_ready), .cq_addr(cq_addr),
  .lm_valid(lm_valid), .lm_ready(lm_ready), .lm_addr(lm_addr),
  .nw_valid(nw_valid), .nw_ready(nw_ready), .nw_addr(nw_addr)
);

// File: tb/sag_top_test.sv
module sag_top_test;
  localparam int AW = 32;
  localparam int SW = 16;
  localparam int SELW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [3:0]    node_id = 4'h1;
  logic          cfg_we = 0;
  logic [SELW-1:0] cfg_sel = 0;
  logic [AW-1:0] cfg_start = 0, cfg_end = 0;
  logic [SW-1:0] cfg_stride = 0;
  logic          cfg_descend = 0, cfg_gather = 0, cfg_store = 0;
  logic          go = 0;
  logic [SELW-1:0] go_sel = 0;
  logic          busy, done;
  logic          idx_valid = 0, idx_ready, idx_last = 0;
  logic [AW-1:0] idx_addr = 0;
  logic [AW-1:0] lkup_addr;
  logic          lkup_hit;
  logic          cq_valid, cq_ready, cq_store;
  logic          lm_valid, lm_ready, lm_store;
  logic          nw_valid, nw_ready, nw_store;
  logic [AW-1:0] cq_addr, lm_addr, nw_addr;
  logic          hit_en = 1'b1;
  int            rdy_mode = 0;

  // tag-check model: hit when address bits [7:4] equal 3
  assign lkup_hit = hit_en && (lkup_addr[7:4] == 4'h3);

  sag_top uut (
    .clk(clk), .rst_n(rst_n), .node_id(node_id),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_start(cfg_start), .cfg_end(cfg_end),
    .cfg_stride(cfg_stride), .cfg_descend(cfg_descend), .cfg_gather(cfg_gather),
    .cfg_store(cfg_store), .go(go), .go_sel(go_sel), .busy(busy), .done(done),
    .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_addr(idx_addr),
    .idx_last(idx_last), .lkup_addr(lkup_addr), .lkup_hit(lkup_hit),
    .cq_valid(cq_valid), .cq_ready(cq_ready), .cq_addr(cq_addr), .cq_store(cq_store),
    .lm_valid(lm_valid), .lm_ready(lm_ready), .lm_addr(lm_addr), .lm_store(lm_store),
    .nw_valid(nw_valid), .nw_ready(nw_ready), .nw_addr(nw_addr), .nw_store(nw_store)
  );

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // ready driver
  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0: begin cq_ready = 1; lm_ready = 1; nw_ready = 1; end
      1: begin cq_ready = cyc[0]; lm_ready = cyc[1]; nw_ready = cyc[0] ^ cyc[1]; end
      default: begin cq_ready = 0; lm_ready = 0; nw_ready = 0; end
    endcase
  end
  initial begin cq_ready = 1; lm_ready = 1; nw_ready = 1; end

  // request log (port: 0 cache, 1 local, 2 network)
  logic [AW-1:0] log_addr [256];
  int            log_port [256];
  logic          log_st   [256];
  int            n_log = 0;
  int            done_cnt = 0, done_cyc = 0, last_fire_cyc = 0;
  int            stall_seen = 0, hold_err = 0;
  logic          prev_stall = 0;
  logic [2:0]    prev_vec = 0;
  logic [AW-1:0] prev_addr = 0;

  task automatic log_req(input int p, input logic [AW-1:0] a, input logic s);
    if (n_log < 256) begin
      log_addr[n_log] = a; log_port[n_log] = p; log_st[n_log] = s;
    end
    n_log++;
    last_fire_cyc = cyc;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0]    vec;
      logic [AW-1:0] cur_a;
      vec = {nw_valid, lm_valid, cq_valid};
      cur_a = cq_valid ? cq_addr : lm_valid ? lm_addr : nw_addr;
      if (prev_stall) begin
        if (vec != prev_vec || cur_a != prev_addr) hold_err++;
      end
      if (cq_valid && cq_ready) log_req(0, cq_addr, cq_store);
      if (lm_valid && lm_ready) log_req(1, lm_addr, lm_store);
      if (nw_valid && nw_ready) log_req(2, nw_addr, nw_store);
      prev_stall = (cq_valid && !cq_ready) || (lm_valid && !lm_ready) ||
                   (nw_valid && !nw_ready);
      if (prev_stall) stall_seen++;
      prev_vec = vec;
      prev_addr = cur_a;
      if (done) begin done_cnt++; done_cyc = cyc; end
    end
  end

  // expected stream
  logic [AW-1:0] exp_addr [256];
  int            exp_port [256];
  logic          exp_st   [256];
  int            n_exp = 0;

  function automatic int route_of(input logic [AW-1:0] a);
    if (hit_en && a[7:4] == 4'h3) return 0;
    if (a[27:24] == node_id) return 1;
    return 2;
  endfunction

  task automatic add_exp(input logic [AW-1:0] a, input logic s);
    exp_addr[n_exp] = a; exp_port[n_exp] = route_of(a); exp_st[n_exp] = s;
    n_exp++;
  endtask

  task automatic gen_strided(input logic [AW-1:0] st, input logic [AW-1:0] lim,
                             input logic [SW-1:0] stp, input logic dn, input logic s);
    logic [AW:0] a;
    n_exp = 0;
    a = {1'b0, st};
    while (n_exp < 256) begin
      if (dn ? (a[AW-1:0] < lim) : (a[AW-1:0] > lim)) break;
      add_exp(a[AW-1:0], s);
      if (stp == 0) break;
      a = dn ? ({1'b0, a[AW-1:0]} - (AW+1)'(stp)) : ({1'b0, a[AW-1:0]} + (AW+1)'(stp));
      if (a[AW]) break;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic cfg_write(input int sel, input logic [AW-1:0] st, input logic [AW-1:0] lim,
                           input logic [SW-1:0] stp, input logic dn, input logic g,
                           input logic s);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = SELW'(sel); cfg_start = st; cfg_end = lim;
    cfg_stride = stp; cfg_descend = dn; cfg_gather = g; cfg_store = s;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic launch(input int sel, input string req);
    n_log = 0; done_cnt = 0;
    @(posedge clk); #1;
    go = 1; go_sel = SELW'(sel);
    @(posedge clk); #1;
    go = 0;
    @(negedge clk);
    chk(busy === 1'b1, req, "busy after launch", 64'(busy), 64'd1);
  endtask

  task automatic finish_check(input string req);
    int w;
    w = 0;
    while (done_cnt == 0 && w < 3000) begin @(negedge clk); w++; end
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R9", "done pulse count", 64'(done_cnt), 64'd1);
    chk(busy == 1'b0, "R9", "busy after done", 64'(busy), 64'd0);
    if (n_log > 0)
      chk(done_cyc > last_fire_cyc, "R9", "done after last accept",
          64'(done_cyc), 64'(last_fire_cyc + 1));
    chk(n_log == n_exp, req, "request count", 64'(n_log), 64'(n_exp));
    for (int i = 0; i < n_exp && i < n_log; i++) begin
      chk(log_addr[i] == exp_addr[i], req, "address", 64'(log_addr[i]), 64'(exp_addr[i]));
      chk(log_port[i] == exp_port[i], "R7", "port", 64'(log_port[i]), 64'(exp_port[i]));
      chk(log_st[i] == exp_st[i], "R10", "store flag", 64'(log_st[i]), 64'(exp_st[i]));
    end
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    @(negedge clk);
    chk(busy == 0, "R1", "busy", 64'(busy), 0);
    chk(done == 0, "R1", "done", 64'(done), 0);
    chk(idx_ready == 0, "R1", "idx_ready", 64'(idx_ready), 0);
    chk({cq_valid, lm_valid, nw_valid} == 3'b000, "R1", "valids",
        64'({cq_valid, lm_valid, nw_valid}), 0);
  endtask

  task automatic t_ascend();  // R3 exact hit on limit, mixed routes
    hit_en = 1;
    cfg_write(0, 32'h0100_0010, 32'h0100_0040, 16'h10, 0, 0, 0);
    gen_strided(32'h0100_0010, 32'h0100_0040, 16'h10, 0, 0);
    launch(0, "R3");
    finish_check("R3");
  endtask

  task automatic t_descend();  // R4, R10 store flag
    cfg_write(1, 32'h0200_0050, 32'h0200_0021, 16'h10, 1, 0, 1);
    gen_strided(32'h0200_0050, 32'h0200_0021, 16'h10, 1, 1);
    launch(1, "R4");
    finish_check("R4");
  endtask

  task automatic t_route_nohit();  // R7: without hit 0x..30 goes local
    hit_en = 0;
    gen_strided(32'h0100_0010, 32'h0100_0040, 16'h10, 0, 0);
    launch(0, "R7");
    finish_check("R7");
    hit_en = 1;
  endtask

  task automatic t_bounds();  // R5 empty, zero stride, wraps (R3/R4)
    cfg_write(2, 32'h0100_0100, 32'h0100_0080, 16'h10, 0, 0, 0);
    gen_strided(32'h0100_0100, 32'h0100_0080, 16'h10, 0, 0);
    launch(2, "R5");
    finish_check("R5");
    cfg_write(2, 32'h0400_0030, 32'h0400_0100, 16'h0, 0, 0, 0);
    gen_strided(32'h0400_0030, 32'h0400_0100, 16'h0, 0, 0);
    launch(2, "R5");
    finish_check("R5");
    cfg_write(2, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 16'h20, 0, 0, 0);
    gen_strided(32'hFFFF_FFF0, 32'hFFFF_FFFF, 16'h20, 0, 0);
    launch(2, "R3");
    finish_check("R3");
    cfg_write(2, 32'h0000_0010, 32'h0000_0000, 16'h20, 1, 0, 1);
    gen_strided(32'h0000_0010, 32'h0000_0000, 16'h20, 1, 1);
    launch(2, "R4");
    finish_check("R4");
  endtask

  task automatic send_idx(input logic [AW-1:0] a, input logic last);
    @(posedge clk); #1;
    idx_valid = 1; idx_addr = a; idx_last = last;
    @(negedge clk);
    while (!idx_ready) @(negedge clk);
    @(posedge clk); #1;
    idx_valid = 0; idx_last = 0;
  endtask

  task automatic t_gather();  // R6
    cfg_write(3, 32'h0, 32'h0, 16'h0, 0, 1, 1);
    @(negedge clk);
    chk(idx_ready == 0, "R6", "idx_ready idle", 64'(idx_ready), 0);
    n_exp = 0;
    add_exp(32'h0100_0500, 1);
    add_exp(32'h0300_0630, 1);
    add_exp(32'h0500_0000, 1);
    add_exp(32'h0100_0730, 1);
    launch(3, "R6");
    send_idx(32'h0100_0500, 0);
    repeat (3) @(posedge clk);
    send_idx(32'h0300_0630, 0);
    send_idx(32'h0500_0000, 0);
    repeat (2) @(posedge clk);
    chk(done_cnt == 0, "R6", "no done before last beat", 64'(done_cnt), 0);
    send_idx(32'h0100_0730, 1);
    finish_check("R6");
  endtask

  task automatic t_backpressure();  // R8, node boundary crossing
    cfg_write(1, 32'h00FF_FFC0, 32'h0100_0040, 16'h10, 0, 0, 1);
    gen_strided(32'h00FF_FFC0, 32'h0100_0040, 16'h10, 0, 1);
    stall_seen = 0; hold_err = 0;
    rdy_mode = 1;
    launch(1, "R8");
    finish_check("R8");
    rdy_mode = 0;
    chk(stall_seen > 0, "R8", "stalls occurred", 64'(stall_seen), 64'd1);
    chk(hold_err == 0, "R8", "held request changed", 64'(hold_err), 0);
  endtask

  task automatic t_busy_isolation();  // R2
    cfg_write(2, 32'h0300_1000, 32'h0300_1070, 16'h10, 0, 0, 0);
    cfg_write(3, 32'h0100_0000, 32'h0100_0010, 16'h10, 0, 0, 0);
    gen_strided(32'h0300_1000, 32'h0300_1070, 16'h10, 0, 0);
    rdy_mode = 2;
    launch(2, "R2");
    cfg_write(2, 32'h0100_2000, 32'h0100_2020, 16'h10, 0, 0, 1);
    @(posedge clk); #1; go = 1; go_sel = 2'd3;
    @(posedge clk); #1; go = 0;
    @(negedge clk);
    chk(busy == 1, "R2", "still busy", 64'(busy), 1);
    rdy_mode = 0;
    finish_check("R2");
    repeat (6) @(negedge clk);
    chk(busy == 0, "R2", "ignored go not queued", 64'(busy), 0);
    chk(n_log == n_exp, "R2", "no extra requests", 64'(n_log), 64'(n_exp));
    gen_strided(32'h0100_2000, 32'h0100_2020, 16'h10, 0, 1);
    launch(2, "R2");
    finish_check("R2");
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_ascend();
    t_descend();
    t_route_nohit();
    t_bounds();
    t_gather();
    t_backpressure();
    t_busy_isolation();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule